// File: doc/BRIEF.md
# PIO Timing Parameter Calculator

This block turns nanosecond timing figures for the two drives that share one disk channel into bus-clock counts. It then packs those counts into the bytes that a channel timing unit loads. For each drive it accepts a presence flag and three times: address setup, active pulse and full cycle. The times come either from the drive's own raw figures or from a built-in table of standard transfer modes. One bus clock frequency in MHz applies to both drives.

A one-cycle `start` pulse latches every input. The block then runs six round-up divisions, one at a time, through a single restoring divider that takes a fixed number of cycles. It clamps every count to the range its field allows and packs one cycle byte per drive, plus one shared byte that carries the common address setup. The new bytes appear together with a one-cycle `done` pulse and are held until the next run finishes. Choosing which mode a drive should run is left to the caller.

Top module: `pio_timing_calc`

## Requirements
- R1: A time of t ns at f MHz converts to (t*f + 999) / 1000 clocks with integer division, which is the ceiling of t*f/1000; 80 ns at 40 MHz gives 4 clocks.
- R2: The recovery time in ns is the cycle time minus the setup time minus the active time, taken as 0 when that difference is negative, and is converted to clocks after the subtraction.
- R3: Clock counts are clamped: address setup to 1..4, data pulse to 1..16, recovery to 2..17.
- R4: A drive whose present flag is 0 uses address 1, data 1 and recovery 2, so its cycle byte is 0x00.
- R5: The shared address setup is the larger of the two drives' clamped address counts.
- R6: A drive's cycle byte holds data-1 in bits 7:4 and recovery-2 in bits 3:0; drive 0 appears on `cycle_byte0` and drive 1 on `cycle_byte1`.
- R7: The shared byte holds `prefetch_en` in bit 6, shared address-1 in bits 5:4 and ready-delay-2 in bits 3:1 (ready delay defaults to 2, giving 0), with bits 7 and 0 at 0.
- R8: When a drive's use-mode bit is 1, its times come from the mode table (setup/active/cycle ns) selected by its 3-bit mode field in `drv_mode`, drive 0 in bits 2:0. The table holds mode 0 = 70/165/600, mode 1 = 50/125/383, mode 2 = 30/100/240, mode 3 = 30/80/180 and mode 4 = 25/70/120. Mode values above 4 act as mode 4.
- R9: A `start` while `busy` is 1 is ignored, and the run in progress finishes on its latched inputs. Each run gives exactly one one-cycle `done` pulse, and the output bytes change only in the cycle `done` is 1.
- R10: After reset, `busy`, `done` and all three output bytes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a calculation; taken only while idle |
| bus_mhz | input | 8 | Bus clock frequency in MHz |
| prefetch_en | input | 1 | Read prefetch bit for the shared byte |
| drv_present | input | 2 | Per-drive presence, drive 0 in bit 0 |
| drv_use_mode | input | 2 | Per-drive choice of table times over raw times |
| drv_mode | input | 6 | Per-drive mode index, 3 bits each |
| drv_setup_ns | input | 20 | Per-drive raw setup time, 10 bits each |
| drv_active_ns | input | 20 | Per-drive raw active time, 10 bits each |
| drv_cycle_ns | input | 20 | Per-drive raw cycle time, 10 bits each |
| busy | output | 1 | A calculation is in progress |
| done | output | 1 | One-cycle pulse when new bytes are valid |
| cycle_byte0 | output | 8 | Drive 0 cycle byte |
| cycle_byte1 | output | 8 | Drive 1 cycle byte |
| misc_byte | output | 8 | Shared address, ready delay and prefetch byte |

## Verification
The divider's exactness check assumes that the sequencer never reissues a division while one is still running. The sequencer guarantees this, because it holds only one division in flight and waits for its valid pulse before it starts the next. The other checks assume nothing about input timing beyond the cycle of the accepted `start`, since every input is latched there. The stimulus keeps every time within 10 bits and every frequency between 8 and 255 MHz, so no product can wrap. It holds the inputs steady only around each start pulse. To exercise the ignore rule it changes them deliberately in the middle of a run.

// File: rtl/pio_calc_pkg.sv
package pio_calc_pkg;

    parameter int TIME_W  = 10;
    parameter int MHZ_W   = 8;
    parameter int NUM_W   = TIME_W + MHZ_W + 1;
    parameter int DEN     = 1000;
    parameter int DEN_W   = $clog2(DEN);
    parameter int NDRV    = 2;
    parameter int NFLD    = 3;
    parameter int NCONV   = NDRV * NFLD;
    parameter int IDX_W   = $clog2(NCONV);
    parameter int MODE_W  = 3;
    parameter int FLD_W   = 5;

    parameter int ADDR_MIN = 1;
    parameter int ADDR_MAX = 4;
    parameter int DATA_MIN = 1;
    parameter int DATA_MAX = 16;
    parameter int REC_MIN  = 2;
    parameter int REC_MAX  = 17;

    typedef logic [TIME_W-1:0] ns_t;
    typedef logic [FLD_W-1:0]  clk_t;

    typedef struct packed {
        ns_t setup;
        ns_t active;
        ns_t cycle;
    } drv_ns_t;

    typedef struct packed {
        ns_t setup;
        ns_t active;
        ns_t recov;
    } conv_ns_t;

    typedef struct packed {
        clk_t addr;
        clk_t data;
        clk_t recov;
    } drv_clk_t;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_ISSUE,
        SEQ_WAIT,
        SEQ_PACK
    } seq_state_t;

    // Standard transfer mode timings; indices past the last mode use the fastest.
    function automatic drv_ns_t std_mode_ns(input logic [MODE_W-1:0] m);
        drv_ns_t r;
        case (m)
            3'd0:    r = '{setup: ns_t'(70), active: ns_t'(165), cycle: ns_t'(600)};
            3'd1:    r = '{setup: ns_t'(50), active: ns_t'(125), cycle: ns_t'(383)};
            3'd2:    r = '{setup: ns_t'(30), active: ns_t'(100), cycle: ns_t'(240)};
            3'd3:    r = '{setup: ns_t'(30), active: ns_t'(80),  cycle: ns_t'(180)};
            default: r = '{setup: ns_t'(25), active: ns_t'(70),  cycle: ns_t'(120)};
        endcase
        return r;
    endfunction

    // Leftover part of the cycle, floored at zero.
    function automatic ns_t recovery_ns(input drv_ns_t t);
        logic [TIME_W:0] used;
        used = {1'b0, t.setup} + {1'b0, t.active};
        if ({1'b0, t.cycle} > used)
            return t.cycle - ns_t'(used);
        return '0;
    endfunction

    function automatic clk_t clamp_clk(input logic [NUM_W-1:0] v, input int lo, input int hi);
        if (v < NUM_W'(lo))
            return clk_t'(lo);
        if (v > NUM_W'(hi))
            return clk_t'(hi);
        return clk_t'(v);
    endfunction

    function automatic logic [7:0] pack_cycle(input drv_clk_t c);
        logic [7:0] hi, lo;
        hi = (8'(c.data) - 8'(DATA_MIN)) << 4;
        lo = 8'(c.recov) - 8'(REC_MIN);
        return hi | lo;
    endfunction

    function automatic logic [7:0] pack_misc(input logic pf, input clk_t addr, input int drdy);
        logic [7:0] r;
        r = ((8'(addr) - 8'(ADDR_MIN)) << 4) | (8'(drdy - 2) << 1);
        if (pf)
            r = r | 8'h40;
        return r;
    endfunction

endpackage

// File: rtl/pio_src_select.sv
module pio_src_select
    import pio_calc_pkg::*;
(
    input  logic              use_mode,
    input  logic [MODE_W-1:0] mode,
    input  drv_ns_t           raw_ns,
    output conv_ns_t          conv
);

    drv_ns_t eff;

    always_comb begin
        eff         = use_mode ? std_mode_ns(mode) : raw_ns;
        conv.setup  = eff.setup;
        conv.active = eff.active;
        conv.recov  = recovery_ns(eff);
    end

endmodule

// File: rtl/pio_ceil_div.sv
module pio_ceil_div #(
    parameter int N_W = 19,
    parameter int D_W = 10
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           go,
    input  logic [N_W-1:0] num,
    input  logic [D_W-1:0] den,
    output logic           vld,
    output logic [N_W-1:0] quo
);

    localparam int CNT_W = $clog2(N_W);
    localparam int P_W   = N_W + D_W;

    logic [D_W:0]     rem;
    logic [N_W-1:0]   sh;
    logic [CNT_W-1:0] cnt;
    logic             run;
    logic [D_W:0]     trial;
    logic             q_bit;
    logic [D_W:0]     next_rem;

    always_comb begin
        trial = {rem[D_W-1:0], sh[N_W-1]};
        if (trial >= {1'b0, den}) begin
            q_bit    = 1'b1;
            next_rem = trial - {1'b0, den};
        end else begin
            q_bit    = 1'b0;
            next_rem = trial;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem <= '0;
            sh  <= '0;
            cnt <= '0;
            run <= 1'b0;
            vld <= 1'b0;
        end else begin
            vld <= 1'b0;
            if (go && !run) begin
                sh  <= num;
                rem <= '0;
                cnt <= '0;
                run <= 1'b1;
            end else if (run) begin
                rem <= next_rem;
                sh  <= {sh[N_W-2:0], q_bit};
                cnt <= cnt + 1'b1;
                if (cnt == CNT_W'(N_W - 1)) begin
                    run <= 1'b0;
                    vld <= 1'b1;
                end
            end
        end
    end

    assign quo = sh;

    // Checking aid: the dividend of the division in flight.
    logic [N_W-1:0] num_hold;
    logic [P_W-1:0] prod_lo, prod_hi, num_ext;

    always_ff @(posedge clk) begin
        if (rst)
            num_hold <= '0;
        else if (go && !run)
            num_hold <= num;
    end

    always_comb begin
        prod_lo = P_W'(quo) * P_W'(den);
        prod_hi = prod_lo + P_W'(den);
        num_ext = P_W'(num_hold);
    end

    AST_DIV_EXACT: assert property (@(posedge clk) disable iff (rst)
        vld |-> (prod_lo <= num_ext) && (num_ext < prod_hi)); // R1
    AST_DIV_NO_REISSUE: assert property (@(posedge clk) disable iff (rst)
        run |-> !go); // R9
    AST_DIV_VLD_PULSE: assert property (@(posedge clk) disable iff (rst)
        vld |=> !vld); // R9

endmodule

// File: rtl/pio_seq.sv
module pio_seq
    import pio_calc_pkg::*;
#(
    parameter int DRDY_CLKS = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [MHZ_W-1:0]    bus_mhz,
    input  logic                prefetch_en,
    input  logic [NDRV-1:0]     drv_present,
    input  conv_ns_t            conv_ns [NDRV],
    output logic                div_go,
    output logic [NUM_W-1:0]    div_num,
    input  logic                div_vld,
    input  logic [NUM_W-1:0]    div_quo,
    output logic                busy,
    output logic                done,
    output logic [NDRV*8-1:0]   cyc_bytes,
    output logic [7:0]          misc_byte
);

    seq_state_t         st;
    logic [IDX_W-1:0]   k;
    ns_t                op_q  [NCONV];
    logic [NUM_W-1:0]   res_q [NCONV];
    logic [MHZ_W-1:0]   mhz_q;
    logic               pf_q;
    logic [NDRV-1:0]    pres_q;
    logic [NDRV*8-1:0]  cyc_q;
    logic [7:0]         misc_q;

    drv_clk_t           dc [NDRV];
    clk_t               addr_sh;
    logic [NDRV*8-1:0]  cyc_next;
    logic [7:0]         misc_next;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= SEQ_IDLE;
            k      <= '0;
            done   <= 1'b0;
            mhz_q  <= '0;
            pf_q   <= 1'b0;
            pres_q <= '0;
            cyc_q  <= '0;
            misc_q <= '0;
            for (int i = 0; i < NCONV; i++) begin
                op_q[i]  <= '0;
                res_q[i] <= '0;
            end
        end else begin
            done <= 1'b0;
            case (st)
                SEQ_IDLE: begin
                    if (start) begin
                        for (int d = 0; d < NDRV; d++) begin
                            op_q[d*NFLD + 0] <= conv_ns[d].setup;
                            op_q[d*NFLD + 1] <= conv_ns[d].active;
                            op_q[d*NFLD + 2] <= conv_ns[d].recov;
                        end
                        mhz_q  <= bus_mhz;
                        pf_q   <= prefetch_en;
                        pres_q <= drv_present;
                        k      <= '0;
                        st     <= SEQ_ISSUE;
                    end
                end
                SEQ_ISSUE: st <= SEQ_WAIT;
                SEQ_WAIT: begin
                    if (div_vld) begin
                        res_q[k] <= div_quo;
                        if (k == IDX_W'(NCONV - 1)) begin
                            st <= SEQ_PACK;
                        end else begin
                            k  <= k + 1'b1;
                            st <= SEQ_ISSUE;
                        end
                    end
                end
                SEQ_PACK: begin
                    cyc_q  <= cyc_next;
                    misc_q <= misc_next;
                    done   <= 1'b1;
                    st     <= SEQ_IDLE;
                end
                default: st <= SEQ_IDLE;
            endcase
        end
    end

    always_comb begin
        div_go  = (st == SEQ_ISSUE);
        div_num = NUM_W'(op_q[k]) * NUM_W'(mhz_q) + NUM_W'(DEN - 1);
    end

    // Clamp, absent-drive override, shared address and byte packing.
    always_comb begin
        addr_sh = clk_t'(ADDR_MIN);
        for (int d = 0; d < NDRV; d++) begin
            if (pres_q[d]) begin
                dc[d].addr  = clamp_clk(res_q[d*NFLD + 0], ADDR_MIN, ADDR_MAX);
                dc[d].data  = clamp_clk(res_q[d*NFLD + 1], DATA_MIN, DATA_MAX);
                dc[d].recov = clamp_clk(res_q[d*NFLD + 2], REC_MIN, REC_MAX);
            end else begin
                dc[d].addr  = clk_t'(ADDR_MIN);
                dc[d].data  = clk_t'(DATA_MIN);
                dc[d].recov = clk_t'(REC_MIN);
            end
            if (dc[d].addr > addr_sh)
                addr_sh = dc[d].addr;
            cyc_next[d*8 +: 8] = pack_cycle(dc[d]);
        end
        misc_next = pack_misc(pf_q, addr_sh, DRDY_CLKS);
    end

    assign busy      = (st != SEQ_IDLE);
    assign cyc_bytes = cyc_q;
    assign misc_byte = misc_q;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R9
    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (st != SEQ_IDLE) |=> $stable(mhz_q) && $stable(pres_q) && $stable(pf_q)); // R9
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(cyc_q) && $stable(misc_q)); // R9
    AST_START_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (st == SEQ_IDLE) && start |=> busy); // R9
    AST_ABSENT_MIN: assert property (@(posedge clk) disable iff (rst)
        done && !pres_q[0] |-> cyc_q[7:0] == 8'h00); // R4
    AST_MISC_SPARE: assert property (@(posedge clk) disable iff (rst)
        done |-> !misc_q[7] && !misc_q[0]); // R7

endmodule

// File: rtl/pio_timing_calc.sv
module pio_timing_calc
    import pio_calc_pkg::*;
#(
    parameter int DRDY_CLKS = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start,
    input  logic [MHZ_W-1:0]         bus_mhz,
    input  logic                     prefetch_en,
    input  logic [NDRV-1:0]          drv_present,
    input  logic [NDRV-1:0]          drv_use_mode,
    input  logic [NDRV*MODE_W-1:0]   drv_mode,
    input  logic [NDRV*TIME_W-1:0]   drv_setup_ns,
    input  logic [NDRV*TIME_W-1:0]   drv_active_ns,
    input  logic [NDRV*TIME_W-1:0]   drv_cycle_ns,
    output logic                     busy,
    output logic                     done,
    output logic [7:0]               cycle_byte0,
    output logic [7:0]               cycle_byte1,
    output logic [7:0]               misc_byte
);

    conv_ns_t          conv_ns [NDRV];
    logic              div_go;
    logic [NUM_W-1:0]  div_num;
    logic              div_vld;
    logic [NUM_W-1:0]  div_quo;
    logic [NDRV*8-1:0] cyc_bytes;

    for (genvar d = 0; d < NDRV; d++) begin : g_drv
        drv_ns_t raw;
        assign raw = {drv_setup_ns[d*TIME_W +: TIME_W],
                      drv_active_ns[d*TIME_W +: TIME_W],
                      drv_cycle_ns[d*TIME_W +: TIME_W]};
        pio_src_select u_src (
            .use_mode (drv_use_mode[d]),
            .mode     (drv_mode[d*MODE_W +: MODE_W]),
            .raw_ns   (raw),
            .conv     (conv_ns[d])
        );
    end

    pio_seq #(.DRDY_CLKS(DRDY_CLKS)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .bus_mhz     (bus_mhz),
        .prefetch_en (prefetch_en),
        .drv_present (drv_present),
        .conv_ns     (conv_ns),
        .div_go      (div_go),
        .div_num     (div_num),
        .div_vld     (div_vld),
        .div_quo     (div_quo),
        .busy        (busy),
        .done        (done),
        .cyc_bytes   (cyc_bytes),
        .misc_byte   (misc_byte)
    );

    pio_ceil_div #(.N_W(NUM_W), .D_W(DEN_W)) u_div (
        .clk (clk),
        .rst (rst),
        .go  (div_go),
        .num (div_num),
        .den (DEN_W'(DEN)),
        .vld (div_vld),
        .quo (div_quo)
    );

    assign cycle_byte0 = cyc_bytes[7:0];
    assign cycle_byte1 = cyc_bytes[15:8];

endmodule

// File: tb/pio_timing_calc_tb.sv
`timescale 1ns/1ps
module pio_timing_calc_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [7:0]  bus_mhz = '0;
    logic        prefetch_en = 1'b0;
    logic [1:0]  drv_present = '0;
    logic [1:0]  drv_use_mode = '0;
    logic [5:0]  drv_mode = '0;
    logic [19:0] drv_setup_ns = '0;
    logic [19:0] drv_active_ns = '0;
    logic [19:0] drv_cycle_ns = '0;
    logic        busy, done;
    logic [7:0]  cycle_byte0, cycle_byte1, misc_byte;

    int n_chk = 0;
    int n_bad = 0;
    int done_cnt = 0;

    always #2 clk = ~clk;

    pio_timing_calc u_dut (
        .clk(clk), .rst(rst), .start(start), .bus_mhz(bus_mhz),
        .prefetch_en(prefetch_en), .drv_present(drv_present),
        .drv_use_mode(drv_use_mode), .drv_mode(drv_mode),
        .drv_setup_ns(drv_setup_ns), .drv_active_ns(drv_active_ns),
        .drv_cycle_ns(drv_cycle_ns), .busy(busy), .done(done),
        .cycle_byte0(cycle_byte0), .cycle_byte1(cycle_byte1), .misc_byte(misc_byte)
    );

    always @(posedge clk) if (!rst && done) done_cnt++;

    task automatic chk(input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", what, act, exp);
        end
    endtask

    function automatic int ceil_clk(input int t, input int m);
        return (t * m + 999) / 1000;
    endfunction

    function automatic int clampi(input int v, input int lo, input int hi);
        if (v < lo) return lo;
        if (v > hi) return hi;
        return v;
    endfunction

    task automatic mode_times(input int m, output int s, output int a, output int c);
        case (m)
            0: begin s = 70; a = 165; c = 600; end
            1: begin s = 50; a = 125; c = 383; end
            2: begin s = 30; a = 100; c = 240; end
            3: begin s = 30; a = 80;  c = 180; end
            default: begin s = 25; a = 70; c = 120; end
        endcase
    endtask

    task automatic ref_drive(input bit pres, input int s, input int a, input int c,
                             input int m, output int ad, output int dt, output int rc);
        int rn;
        if (!pres) begin
            ad = 1; dt = 1; rc = 2;
        end else begin
            rn = c - s - a;
            if (rn < 0) rn = 0;
            ad = clampi(ceil_clk(s, m), 1, 4);
            dt = clampi(ceil_clk(a, m), 1, 16);
            rc = clampi(ceil_clk(rn, m), 2, 17);
        end
    endtask

    task automatic wait_done();
        int n = 0;
        while (!done && n < 1000) begin
            @(negedge clk);
            n++;
        end
        if (!done) chk("R9 done never pulsed", 0, 1);
    endtask

    // Drives one calculation and compares all three bytes to the reference.
    task automatic run_case(input int mhz, input bit pf, input bit [1:0] pres,
                            input bit [1:0] um, input int m0, input int m1,
                            input int s0, input int a0, input int c0,
                            input int s1, input int a1, input int c1,
                            input string tag);
        int es0, ea0, ec0, es1, ea1, ec1;
        int ad0, dt0, rc0, ad1, dt1, rc1, ax;
        bus_mhz       = 8'(mhz);
        prefetch_en   = pf;
        drv_present   = pres;
        drv_use_mode  = um;
        drv_mode      = {3'(m1), 3'(m0)};
        drv_setup_ns  = {10'(s1), 10'(s0)};
        drv_active_ns = {10'(a1), 10'(a0)};
        drv_cycle_ns  = {10'(c1), 10'(c0)};
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        if (um[0]) mode_times(m0, es0, ea0, ec0); else begin es0 = s0; ea0 = a0; ec0 = c0; end
        if (um[1]) mode_times(m1, es1, ea1, ec1); else begin es1 = s1; ea1 = a1; ec1 = c1; end
        ref_drive(pres[0], es0, ea0, ec0, mhz, ad0, dt0, rc0);
        ref_drive(pres[1], es1, ea1, ec1, mhz, ad1, dt1, rc1);
        ax = (ad0 > ad1) ? ad0 : ad1;
        chk({tag, " R1 R2 R3 R4 R6 R8 cycle_byte0"}, cycle_byte0, ((dt0 - 1) << 4) | (rc0 - 2));
        chk({tag, " R1 R2 R3 R4 R6 R8 cycle_byte1"}, cycle_byte1, ((dt1 - 1) << 4) | (rc1 - 2));
        chk({tag, " R5 R7 misc_byte"}, misc_byte, (pf ? 64 : 0) | ((ax - 1) << 4));
        @(negedge clk);
        chk({tag, " R9 done one cycle"}, done, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R9 watchdog expired: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        chk("R10 reset busy", busy, 0);
        chk("R10 reset done", done, 0);
        chk("R10 reset cycle_byte0", cycle_byte0, 0);
        chk("R10 reset cycle_byte1", cycle_byte1, 0);
        chk("R10 reset misc_byte", misc_byte, 0);
        rst = 1'b0;
        @(negedge clk);

        // R1: 80 ns active at 40 MHz must give 4 data clocks (field value 3).
        run_case(40, 0, 2'b01, 2'b00, 0, 0, 30, 80, 200, 0, 0, 0, "r1_80ns");
        chk("R1 80ns@40MHz cycle_byte0", cycle_byte0, 8'h32);
        chk("R1 R5 80ns@40MHz misc_byte", misc_byte, 8'h10);

        // R2/R3: negative recovery floors to 0 ns, then clamps to 2 clocks.
        run_case(50, 0, 2'b01, 2'b00, 0, 0, 100, 100, 50, 0, 0, 0, "r2_neg");
        chk("R2 R3 negative recovery cycle_byte0", cycle_byte0, 8'h40);
        chk("R3 address clamp misc_byte", misc_byte, 8'h30);

        // R3: upper clamps on data and recovery.
        run_case(100, 1, 2'b10, 2'b00, 0, 0, 0, 0, 0, 50, 400, 1000, "r3_high");
        chk("R3 upper clamp cycle_byte1", cycle_byte1, 8'hFF);
        chk("R4 absent drive0 cycle_byte0", cycle_byte0, 8'h00);
        chk("R7 prefetch misc_byte", misc_byte, 8'h70);

        // R8: mode index 7 behaves as mode 4.
        run_case(33, 0, 2'b11, 2'b11, 7, 4, 0, 0, 0, 0, 0, 0, "r8_over");
        chk("R8 mode 7 as mode 4 cycle_byte0", cycle_byte0, 8'h20);
        chk("R8 mode 4 cycle_byte1", cycle_byte1, 8'h20);

        // R8 sweep: all table modes (plus one past the end) across bus speeds.
        for (int fi = 0; fi < 6; fi++) begin
            int mhz;
            case (fi)
                0: mhz = 20; 1: mhz = 25; 2: mhz = 33;
                3: mhz = 40; 4: mhz = 50; default: mhz = 66;
            endcase
            for (int m0 = 0; m0 < 6; m0++)
                for (int m1 = 0; m1 < 6; m1++)
                    run_case(mhz, (m0 + m1) % 2, 2'b11, 2'b11, m0, m1,
                             0, 0, 0, 0, 0, 0, "r8_sweep");
        end

        // Raw-time sweep over presence patterns, prefetch and frequencies.
        for (int i = 0; i < 80; i++) begin
            run_case(8 + (i * 29) % 248, i % 2, 2'(i % 4), 2'b00, 0, 0,
                     5 + (i * 37) % 250, 20 + (i * 53) % 400, (i * 97) % 1024,
                     5 + (i * 71) % 200, 10 + (i * 43) % 500, (i * 131) % 1024,
                     "r1_raw");
        end

        // R9: a second start during a run is ignored.
        begin
            int base;
            base = done_cnt;
            bus_mhz = 8'd40; prefetch_en = 1'b0; drv_present = 2'b01; drv_use_mode = 2'b00;
            drv_setup_ns = {10'd0, 10'd30}; drv_active_ns = {10'd0, 10'd80};
            drv_cycle_ns = {10'd0, 10'd200};
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            repeat (10) @(negedge clk);
            chk("R9 busy during run", busy, 1);
            bus_mhz = 8'd200; prefetch_en = 1'b1; drv_present = 2'b11;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            wait_done();
            chk("R9 ignored start cycle_byte0", cycle_byte0, 8'h32);
            chk("R9 ignored start misc_byte", misc_byte, 8'h10);
            repeat (300) @(negedge clk);
            chk("R9 single done pulse", done_cnt - base, 1);
            chk("R9 idle after run", busy, 0);
            chk("R9 outputs held cycle_byte0", cycle_byte0, 8'h32);
            chk("R9 outputs held misc_byte", misc_byte, 8'h10);
        end

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule